// File: doc/BRIEF.md
# Converter Parallel Bus Interface Logic

This block is the digital front end that sits between a 12-bit successive-approximation conversion core and a host's parallel bus. A host starts a conversion with a falling edge on an asynchronous start strobe. The block then holds its busy pin low for a fixed number of system clocks. The converted code comes from a sampled code port that stands in for the analog core. The block adds a host-written offset to that code and places the sum in an output register. A 13-bit data bus, split into data-in, data-out and an output-enable, is driven under chip-select and read, and takes offset writes under chip-select and a write pulse.

Two result-latching modes are offered. In the immediate mode, the output register takes the result as busy returns high. In the deferred mode, the result is parked when busy returns high and moves to the output register only on the next accepted start, which gives one sample of latency. All host strobes pass through two-flop synchronizers before their edges are detected.

Error reporting covers three cases. An invalid mode code is flagged. A start that arrives during a conversion is ignored and sets a sticky error flag. A read during a conversion is served, and it sets a separate sticky flag. Power-saving inputs only block new conversions.

Top module: `adc_par_iface`

## Requirements
- R1: After reset busy_o is high (idle). A synchronized falling edge on convst_i, accepted in a valid mode, drives busy_o low.
- R2: Once low, busy_o stays low for exactly CONV_CYCLES clock cycles and then returns high.
- R3: mode_i = 2'b01 selects immediate mode and mode_i = 2'b10 selects deferred mode. With 2'b00 or 2'b11, mode_err_o is high and start edges are ignored.
- R4: In immediate mode, the output register takes (sampled code + offset) in the cycle busy_o rises. sample_i is captured on the accepted start edge.
- R5: In deferred mode, the result is held internally when busy_o rises. It enters the output register on the next accepted start edge. Until then, the output register keeps its earlier content, and that content is 0 after reset.
- R6: data_oe_o is high only while both synchronized cs_ni and rd_ni are low. data_o then carries the output register.
- R7: A synchronized falling edge of wr_i while cs_ni is low latches data_i into the offset register. With cs_ni high, the write is ignored. The sum with the sampled code wraps modulo 2^13.
- R8: Asserting rst_ni low at once returns busy_o high and aborts any conversion. It also clears the offset, the output and parked results, and both sticky flags.
- R9: A start edge while busy_o is low is ignored: the busy duration is unchanged. It also sets start_err_o, which stays high until reset.
- R10: A read while busy_o is low still drives the bus, and it sets rd_err_o, which stays high until reset.
- R11: While nap_i or stby_i is high, start edges are ignored and busy_o stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| convst_i | input | 1 | Asynchronous convert-start strobe, falling edge active |
| cs_ni | input | 1 | Chip select, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wr_i | input | 1 | Write pulse; offset latched on its falling edge |
| mode_i | input | 2 | Result-latching mode select |
| nap_i | input | 1 | Nap request; blocks new conversions |
| stby_i | input | 1 | Standby request; blocks new conversions |
| sample_i | input | 13 | Code from the conversion core |
| data_i | input | 13 | Bus data in (offset word) |
| data_o | output | 13 | Bus data out |
| data_oe_o | output | 1 | Bus output enable (high drives the bus) |
| busy_o | output | 1 | Low while a conversion runs |
| mode_err_o | output | 1 | Reserved mode code selected |
| start_err_o | output | 1 | Sticky: start seen during conversion |
| rd_err_o | output | 1 | Sticky: read during conversion |

## Verification
The assertions check several properties on every cycle. Busy holds low while the counter runs. An accepted start always drops busy, and a blocked or invalid-mode start never does. The output register is frozen while the block is idle, outside the latch points. Both sticky flags never clear by themselves, and the offset only changes on a write edge. The bench scenarios show what the assertions do not. These are the exact busy length, the arithmetic of offset and wrap-around, the one-sample lag of deferred mode, the effect of chip-select on writes and reads, and the clearing of all state by a mid-conversion reset.

// File: rtl/adc_if_pkg.sv
package adc_if_pkg;
  typedef enum logic [1:0] {
    MODE_RSV_LO = 2'b00,
    MODE_IMMED  = 2'b01,
    MODE_DEFER  = 2'b10,
    MODE_RSV_HI = 2'b11
  } par_mode_e;

  function automatic logic mode_valid(input par_mode_e m);
    return (m == MODE_IMMED) || (m == MODE_DEFER);
  endfunction
endpackage

// File: rtl/adc_sync.sv
module adc_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] q1, q2, q3;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q1[i] <= RST_VAL[i];
        q2[i] <= RST_VAL[i];
        q3[i] <= RST_VAL[i];
      end else begin
        q1[i] <= async_i[i];
        q2[i] <= q1[i];
        q3[i] <= q2[i];
      end
    end
    assign fall_o[i] = q3[i] & ~q2[i];
  end

  assign lvl_o = q2;
endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl
  import adc_if_pkg::*;
#(
  parameter int DATA_W      = 13,
  parameter int CONV_CYCLES = 30
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  par_mode_e         mode_i,
  input  logic              hold_i,
  input  logic [DATA_W-1:0] sample_i,
  input  logic [DATA_W-1:0] offset_i,
  output logic              busy_o,
  output logic [DATA_W-1:0] out_word_o,
  output logic              start_err_o
);
  localparam int CNT_W = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(CONV_CYCLES - 1);

  logic              idle_q;
  logic [CNT_W-1:0]  cnt_q;
  par_mode_e         mode_q;
  logic [DATA_W-1:0] smp_q, pend_q, out_q;
  logic              serr_q;
  logic              accept;
  logic [DATA_W-1:0] sum;

  assign accept = idle_q && start_i && mode_valid(mode_i) && !hold_i;
  assign sum    = smp_q + offset_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idle_q <= 1'b1;
      cnt_q  <= '0;
      mode_q <= MODE_IMMED;
      smp_q  <= '0;
      pend_q <= '0;
      out_q  <= '0;
      serr_q <= 1'b0;
    end else if (idle_q) begin
      if (accept) begin
        idle_q <= 1'b0;
        cnt_q  <= CNT_LOAD;
        mode_q <= mode_i;
        smp_q  <= sample_i;
        if (mode_i == MODE_DEFER) out_q <= pend_q;
      end
    end else begin
      if (start_i) serr_q <= 1'b1;
      if (cnt_q == '0) begin
        idle_q <= 1'b1;
        if (mode_q == MODE_IMMED) out_q <= sum;
        else                      pend_q <= sum;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign busy_o      = idle_q;
  assign out_word_o  = out_q;
  assign start_err_o = serr_q;

  AST_START_DROPS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_q && start_i && mode_valid(mode_i) && !hold_i |=> !idle_q); // R1
  AST_BUSY_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idle_q && cnt_q != '0 |=> !idle_q); // R2
  AST_BAD_MODE_NO_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_q && !mode_valid(mode_i) |=> idle_q); // R3
  AST_OUT_FROZEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_q && $past(idle_q) |-> $stable(out_q)); // R4
  AST_START_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    serr_q |=> serr_q); // R9
  AST_HOLD_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_q && hold_i |=> idle_q); // R11
endmodule

// File: rtl/adc_bus_port.sv
module adc_bus_port #(
  parameter int DATA_W = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_n_i,
  input  logic              rd_n_i,
  input  logic              wr_fall_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              busy_i,
  input  logic [DATA_W-1:0] out_word_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic [DATA_W-1:0] offset_o,
  output logic              rd_err_o
);
  logic [DATA_W-1:0] offset_q;
  logic              rerr_q;
  logic              oe;

  assign oe = ~cs_n_i & ~rd_n_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      offset_q <= '0;
      rerr_q   <= 1'b0;
    end else begin
      if (wr_fall_i && !cs_n_i) offset_q <= data_i;
      if (oe && !busy_i)        rerr_q   <= 1'b1;
    end
  end

  assign data_oe_o = oe;
  assign data_o    = oe ? out_word_i : '0;
  assign offset_o  = offset_q;
  assign rd_err_o  = rerr_q;

  AST_OFFSET_ONLY_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_fall_i |=> $stable(offset_q)); // R7
  AST_RD_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rerr_q |=> rerr_q); // R10
  AST_OE_NEEDS_SELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_i |-> !data_oe_o); // R6
endmodule

// File: rtl/adc_par_iface.sv
module adc_par_iface
  import adc_if_pkg::*;
#(
  parameter int DATA_W      = 13,
  parameter int CONV_CYCLES = 30
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              convst_i,
  input  logic              cs_ni,
  input  logic              rd_ni,
  input  logic              wr_i,
  input  logic [1:0]        mode_i,
  input  logic              nap_i,
  input  logic              stby_i,
  input  logic [DATA_W-1:0] sample_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              busy_o,
  output logic              mode_err_o,
  output logic              start_err_o,
  output logic              rd_err_o
);
  localparam int NSYNC = 4;
  // bit order: convst, cs_n, rd_n, wr ; idle levels high, high, high, low
  localparam logic [NSYNC-1:0] SYNC_RST = 4'b1110;

  logic [NSYNC-1:0]  s_lvl, s_fall;
  logic [DATA_W-1:0] offset, out_word;
  logic              busy;
  par_mode_e         mode;

  assign mode = par_mode_e'(mode_i);

  adc_sync #(.W(NSYNC), .RST_VAL(SYNC_RST)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i({convst_i, cs_ni, rd_ni, wr_i}),
    .lvl_o  (s_lvl),
    .fall_o (s_fall)
  );

  adc_conv_ctrl #(.DATA_W(DATA_W), .CONV_CYCLES(CONV_CYCLES)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (s_fall[3]),
    .mode_i     (mode),
    .hold_i     (nap_i | stby_i),
    .sample_i   (sample_i),
    .offset_i   (offset),
    .busy_o     (busy),
    .out_word_o (out_word),
    .start_err_o(start_err_o)
  );

  adc_bus_port #(.DATA_W(DATA_W)) u_bus (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_n_i    (s_lvl[2]),
    .rd_n_i    (s_lvl[1]),
    .wr_fall_i (s_fall[0]),
    .data_i    (data_i),
    .busy_i    (busy),
    .out_word_i(out_word),
    .data_o    (data_o),
    .data_oe_o (data_oe_o),
    .offset_o  (offset),
    .rd_err_o  (rd_err_o)
  );

  assign busy_o     = busy;
  assign mode_err_o = !mode_valid(mode);

  AST_MODE_ERR_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_err_o && busy_o |=> busy_o); // R3
endmodule

// File: tb/tb_adc_par_iface.sv
module tb_adc_par_iface;
  localparam int CLK_PERIOD = 10;
  localparam int DW   = 13;
  localparam int CONV = 30;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          convst_i = 1'b1, cs_ni = 1'b1, rd_ni = 1'b1, wr_i = 1'b0;
  logic [1:0]    mode_i = 2'b01;
  logic          nap_i = 1'b0, stby_i = 1'b0;
  logic [DW-1:0] sample_i = '0, data_i = '0;
  logic [DW-1:0] data_o;
  logic          data_oe_o, busy_o, mode_err_o, start_err_o, rd_err_o;

  int n_chk = 0, n_fail = 0;
  int low_cnt = 0, last_len = 0;
  int exp_q[$];
  event rd_ev;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_par_iface #(.DATA_W(DW), .CONV_CYCLES(CONV)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .convst_i(convst_i), .cs_ni(cs_ni),
    .rd_ni(rd_ni), .wr_i(wr_i), .mode_i(mode_i), .nap_i(nap_i),
    .stby_i(stby_i), .sample_i(sample_i), .data_i(data_i), .data_o(data_o),
    .data_oe_o(data_oe_o), .busy_o(busy_o), .mode_err_o(mode_err_o),
    .start_err_o(start_err_o), .rd_err_o(rd_err_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // busy low-time monitor
  always @(negedge clk) begin
    if (!rst_ni) low_cnt = 0;
    else if (!busy_o) low_cnt++;
    else if (low_cnt != 0) begin last_len = low_cnt; low_cnt = 0; end
  end

  // scoreboard monitor: pops expected word for each read strobe
  always @(rd_ev) begin
    if (exp_q.size() == 0) begin
      n_chk++; n_fail++;
      $display("FAIL R6 actual=%0d expected=<empty queue>", data_o);
    end else begin
      int e;
      e = exp_q.pop_front();
      check("R6 oe during read", data_oe_o, 1);
      check("R4/R5/R7 bus word", data_o, e);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start(input int s);
    sample_i = DW'(s);
    convst_i = 1'b0;
    cyc(4);
    convst_i = 1'b1;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 4 * CONV && !busy_o; i++) cyc(1);
    cyc(1);
  endtask

  task automatic convert(input int s);
    last_len = 0;
    pulse_start(s);
    wait_idle();
    check("R2 busy length", last_len, CONV);
  endtask

  task automatic write_off(input int v, input logic cs);
    cs_ni = cs; data_i = DW'(v); wr_i = 1'b1;
    cyc(4);
    wr_i = 1'b0;
    cyc(4);
    cs_ni = 1'b1;
    cyc(3);
  endtask

  task automatic read_word(input int e);
    exp_q.push_back(e);
    cs_ni = 1'b0; rd_ni = 1'b0;
    cyc(4);
    -> rd_ev;
    cyc(1);
    cs_ni = 1'b1; rd_ni = 1'b1;
    cyc(3);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    cyc(3);
    rst_ni = 1'b1;
    cyc(2);
    check("R1 busy idle after reset", busy_o, 1);
    check("R8 oe off after reset", data_oe_o, 0);
    check("R8 start_err clear", start_err_o, 0);
    check("R8 rd_err clear", rd_err_o, 0);

    // R3 mode decode
    mode_i = 2'b00; cyc(1); check("R3 mode 00 invalid", mode_err_o, 1);
    pulse_start(11); cyc(6); check("R3 start ignored in mode 00", busy_o, 1);
    mode_i = 2'b11; cyc(1); check("R3 mode 11 invalid", mode_err_o, 1);
    mode_i = 2'b10; cyc(1); check("R3 mode 10 valid", mode_err_o, 0);
    mode_i = 2'b01; cyc(1); check("R3 mode 01 valid", mode_err_o, 0);

    // R1/R2/R4 immediate mode
    pulse_start(100);
    check("R1 busy low after start", busy_o, 0);
    wait_idle();
    check("R2 busy length", last_len, CONV);
    read_word(100);

    // R6 partial selects
    cs_ni = 1'b0; cyc(4); check("R6 cs only no drive", data_oe_o, 0);
    cs_ni = 1'b1; rd_ni = 1'b0; cyc(4); check("R6 rd only no drive", data_oe_o, 0);
    rd_ni = 1'b1; cyc(3);

    // R7 offset
    write_off(5, 1'b0);
    convert(200); read_word(205);
    write_off(77, 1'b1);
    convert(10); read_word(15);
    write_off(2, 1'b0);
    convert(8191); read_word(1);

    // R5 deferred mode
    write_off(0, 1'b0);
    mode_i = 2'b10;
    convert(300); read_word(0);
    convert(400); read_word(300);
    convert(500); read_word(400);
    mode_i = 2'b01;

    // R9 start during conversion
    check("R9 start_err clear before", start_err_o, 0);
    last_len = 0;
    pulse_start(60);
    cyc(5);
    pulse_start(61);
    wait_idle();
    check("R9 busy length unchanged", last_len, CONV);
    check("R9 start_err set", start_err_o, 1);
    read_word(60);
    cyc(5);
    check("R9 start_err sticky", start_err_o, 1);

    // R10 read during conversion
    check("R10 rd_err clear before", rd_err_o, 0);
    pulse_start(70);
    cs_ni = 1'b0; rd_ni = 1'b0;
    cyc(4);
    check("R10 bus driven while busy", data_oe_o, 1);
    check("R10 rd_err set", rd_err_o, 1);
    cs_ni = 1'b1; rd_ni = 1'b1;
    wait_idle();
    check("R10 rd_err sticky", rd_err_o, 1);

    // R11 power gating
    nap_i = 1'b1; pulse_start(80); cyc(6);
    check("R11 nap blocks start", busy_o, 1);
    nap_i = 1'b0; stby_i = 1'b1; pulse_start(81); cyc(6);
    check("R11 standby blocks start", busy_o, 1);
    stby_i = 1'b0;
    read_word(70);

    // R8 reset mid-conversion
    write_off(9, 1'b0);
    pulse_start(90);
    cyc(2);
    check("R8 busy low before reset", busy_o, 0);
    rst_ni = 1'b0;
    #1;
    check("R8 reset aborts conversion", busy_o, 1);
    cyc(2);
    rst_ni = 1'b1;
    cyc(3);
    check("R8 start_err cleared", start_err_o, 0);
    check("R8 rd_err cleared", rd_err_o, 0);
    read_word(0);
    convert(50); read_word(50);

    cyc(5);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule